// File: doc/BRIEF.md
# Unaligned Access Splitter

The splitter sits between a load/store unit and a memory bus that only carries naturally aligned byte, halfword and word transfers. Each request has an address, a size, a direction flag and 32-bit write data. A request whose address fits its size goes to the bus unchanged as one transfer. A misaligned request is broken into the fewest aligned pieces. Those pieces go to the bus in ascending address order, one piece per bus handshake. For reads, the returned pieces are combined little-endian into one result.

A request is taken when `req_valid` is high and `busy` is low. From the next cycle the block drives `bus_req`. It holds each piece on the bus until `bus_ack` arrives, then presents the following piece one cycle later. The memory can insert wait states by holding `bus_ack` low, and each piece then lasts longer by that many cycles. When the last piece is acknowledged, `done` pulses for one cycle and `rdata` holds the merged read value.

Top module: `unaligned_splitter`

## Requirements
- R1: A byte request, an even-address halfword, or a word at an address whose two low bits are zero produces exactly one bus transfer at the same address and size. The size encoding is 0 = byte, 1 = halfword, 2 = word.
- R2: A halfword at an odd address produces two byte transfers, at the address and then at the address plus one.
- R3: A word whose address has low bits 2'b10 produces two halfword transfers, at the address and then at the address plus two.
- R4: A word at an odd address produces three transfers in this order: a byte at the address, a halfword at the address plus one, and a byte at the address plus three.
- R5: Every bus transfer is naturally aligned for its size. Its address, size and data stay stable while `bus_req` is high and `bus_ack` is low. The next piece appears in the cycle after an acknowledge, so with zero wait states a request of N pieces keeps `bus_req` high for N cycles.
- R6: For a write, each piece carries the next unsent request bytes, lowest first, on bus byte lanes starting at lane `bus_addr[1:0]`. Lane k is `bus_wdata[8k+7:8k]`. Lanes outside the piece are zero.
- R7: For a read, the byte at the lowest address lands in `rdata[7:0]` and each following byte lands in the next higher lane. Byte and halfword results are zero-extended. `rdata` is valid while `done` is high.
- R8: `done` is a single-cycle pulse in the cycle after the final acknowledge. `busy` is high from the cycle after acceptance through the cycle of the final acknowledge. `bus_req` is never high while `busy` is low.
- R9: A request presented while `busy` is high is ignored. It causes no bus transfer, either then or after the current request completes.
- R10: With W wait states per piece, a request of N pieces keeps `bus_req` high for N×(W+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, least significant byte at the lowest address |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Merged read result |
| bus_req | output | 1 | Aligned transfer valid |
| bus_addr | output | 32 | Transfer address |
| bus_size | output | 2 | Transfer size, same encoding as req_size |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Write data on address-selected lanes |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data on address-selected lanes |

## Verification
The bench sweeps every size against all four address offsets, for both reads and writes, with 0, 1 and 3 wait states. Each case starts from a fresh byte pattern. The offset sweep separates the one-, two- and three-piece splits, and it shows whether odd offsets 1 and 3 take the byte/halfword/byte path in ascending order. Comparing the read result and the whole memory image catches lane placement and endian errors. The wait-state variation separates piece hold and sequencing faults from faults in the split itself. A separate run drives a second request during a busy transfer.

// File: rtl/usplit_pkg.sv
// Shared size encoding and helpers for the unaligned access splitter.
package usplit_pkg;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Byte count of a size code; the unused code 3 counts as a word.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Lane mask for a piece of 1, 2 or 4 bytes.
    function automatic logic [31:0] bytes_mask(input logic [2:0] nb);
        case (nb)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/usplit_piece_sel.sv
// Chooses the next aligned piece. It takes the largest size that the current
// address is aligned to and that does not exceed the bytes still to move.
// Assumes remain is 1..4.
module usplit_piece_sel (
    input  logic [1:0] cur_lo,
    input  logic [2:0] remain,
    output logic [1:0] piece_size,
    output logic [2:0] piece_bytes
);
    import usplit_pkg::*;

    // Greedy choice: word, else halfword, else byte.
    always_comb begin
        if (cur_lo == 2'd0 && remain >= 3'd4) begin
            piece_size = SZ_WORD;
        end else if (!cur_lo[0] && remain >= 3'd2) begin
            piece_size = SZ_HALF;
        end else begin
            piece_size = SZ_BYTE;
        end
        piece_bytes = size_bytes(piece_size);
    end
endmodule

// File: rtl/usplit_wr_lane.sv
// Takes the request bytes for the current piece and places them on the bus
// lanes given by the piece address. Lanes outside the piece are driven zero.
module usplit_wr_lane #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        done_bytes,
    input  logic [1:0]        lane,
    input  logic [2:0]        piece_bytes,
    output logic [DATA_W-1:0] lane_data
);
    import usplit_pkg::*;

    logic [DATA_W-1:0] src;

    // Drop the bytes already sent, keep the piece width, then move it to its lane.
    always_comb begin
        src       = (wdata >> {done_bytes, 3'b000}) & bytes_mask(piece_bytes);
        lane_data = src << {lane, 3'b000};
    end
endmodule

// File: rtl/usplit_rd_merge.sv
// Takes the bytes of one returned piece off their bus lanes. It ORs them into
// the accumulator at the position given by the bytes already collected.
module usplit_rd_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        lane,
    input  logic [2:0]        piece_bytes,
    input  logic [1:0]        done_bytes,
    input  logic [DATA_W-1:0] acc_in,
    output logic [DATA_W-1:0] acc_out
);
    import usplit_pkg::*;

    logic [DATA_W-1:0] piece;

    // Little-endian merge: later pieces fill higher result bytes.
    always_comb begin
        piece   = (bus_rdata >> {lane, 3'b000}) & bytes_mask(piece_bytes);
        acc_out = acc_in | (piece << {done_bytes, 3'b000});
    end
endmodule

// File: rtl/unaligned_splitter.sv
// Turns one byte, halfword or word access at any address into a sequence of
// naturally aligned bus transfers, in ascending address order. One piece is
// in flight at a time, and the next piece is issued the cycle after an ack.
// Assumes the bus returns read data on address-selected lanes and that the
// requester waits for busy low before presenting a request.
module unaligned_splitter #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    import usplit_pkg::*;

    localparam int DATA_W = 32;

    logic              active_q;
    logic              done_q;
    logic [ADDR_W-1:0] cur_q;
    logic [2:0]        remain_q;
    logic [1:0]        sent_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] rdata_q;

    logic [1:0]        piece_size;
    logic [2:0]        piece_bytes;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] acc_next;
    logic              accept;
    logic              fire;
    logic              last;

    usplit_piece_sel u_sel (
        .cur_lo      (cur_q[1:0]),
        .remain      (remain_q),
        .piece_size  (piece_size),
        .piece_bytes (piece_bytes)
    );

    usplit_wr_lane #(.DATA_W(DATA_W)) u_wr (
        .wdata       (wdata_q),
        .done_bytes  (sent_q),
        .lane        (cur_q[1:0]),
        .piece_bytes (piece_bytes),
        .lane_data   (lane_wdata)
    );

    usplit_rd_merge #(.DATA_W(DATA_W)) u_rd (
        .bus_rdata   (bus_rdata),
        .lane        (cur_q[1:0]),
        .piece_bytes (piece_bytes),
        .done_bytes  (sent_q),
        .acc_in      (acc_q),
        .acc_out     (acc_next)
    );

    // Handshake decode: take a new request when idle, advance on ack.
    always_comb begin
        accept = req_valid && !active_q;
        fire   = active_q && bus_ack;
        last   = fire && (remain_q == piece_bytes);
    end

    // Sequencer state: load on accept, step one piece per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            cur_q    <= '0;
            remain_q <= '0;
            sent_q   <= '0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
            acc_q    <= '0;
            rdata_q  <= '0;
        end else begin
            done_q <= last;
            if (accept) begin
                active_q <= 1'b1;
                cur_q    <= req_addr;
                remain_q <= size_bytes(req_size);
                sent_q   <= '0;
                write_q  <= req_write;
                wdata_q  <= req_wdata;
                acc_q    <= '0;
            end else if (fire) begin
                cur_q    <= cur_q + ADDR_W'(piece_bytes);
                remain_q <= remain_q - piece_bytes;
                sent_q   <= sent_q + piece_bytes[1:0];
                acc_q    <= acc_next;
                if (last) begin
                    active_q <= 1'b0;
                    rdata_q  <= acc_next;
                end
            end
        end
    end

    // Output drive straight from state and the piece logic.
    always_comb begin
        busy      = active_q;
        done      = done_q;
        rdata     = rdata_q;
        bus_req   = active_q;
        bus_addr  = cur_q;
        bus_size  = piece_size;
        bus_write = write_q;
        bus_wdata = write_q ? lane_wdata : '0;
    end
endmodule

// File: rtl/usplit_checker.sv
// Protocol checks for unaligned_splitter, attached with bind.
module usplit_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_write,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack
);
    AST_PIECE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata)); // R5

    AST_NATURAL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !((bus_size == 2'd1) && bus_addr[0]) && !((bus_size == 2'd2) && (bus_addr[1:0] != 2'd0))); // R5

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ack)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R8

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_write && (bus_size == 2'd0) |-> (bus_wdata & ~(32'h0000_00FF << {bus_addr[1:0], 3'b000})) == 32'd0); // R6
endmodule

bind unaligned_splitter usplit_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/unaligned_splitter_tb.sv
module unaligned_splitter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, bus_req, bus_write;
    logic [31:0] rdata, bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int lane_err = 0;
    int lg_n = 0;
    logic [31:0] lg_addr [0:7];
    logic [1:0]  lg_size [0:7];
    logic [7:0]  mem [0:63];
    logic [7:0]  ref_mem [0:63];

    always #2.5 clk = ~clk;

    unaligned_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory model: waits wait_cfg cycles per piece, lane-placed data, logs pieces.
    always @(negedge clk) begin
        if (bus_req) begin
            if (wcnt >= wait_cfg) begin
                automatic int nb = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
                automatic int ln = int'(bus_addr[1:0]);
                automatic logic [5:0] wb = {bus_addr[5:2], 2'b00};
                for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = mem[wb + 6'(l)];
                if (lg_n < 8) begin
                    lg_addr[lg_n] = bus_addr;
                    lg_size[lg_n] = bus_size;
                end
                lg_n++;
                if (bus_write) begin
                    for (int l = 0; l < 4; l++) begin
                        if (l >= ln && l < ln + nb) mem[wb + 6'(l)] = bus_wdata[8*l +: 8];
                        else if (bus_wdata[8*l +: 8] != 8'h00) lane_err++;
                    end
                end
                bus_ack = 1'b1;
                wcnt = 0;
            end else begin
                bus_ack = 1'b0;
                wcnt++;
            end
        end else begin
            bus_ack = 1'b0;
            wcnt = 0;
        end
    end

    function automatic string tag_of(input int sz, input int off);
        if (sz == 1 && off[0]) return "R2";
        if (sz == 2 && off == 2) return "R3";
        if (sz == 2 && off[0]) return "R4";
        return "R1";
    endfunction

    task automatic run_one(input int base, input int sz, input bit wr, input logic [31:0] wd,
                           input int w, input bit hammer);
        int off, n, nb, cyc, tmo;
        int e_rel [0:2];
        int e_sz  [0:2];
        logic [31:0] exp_rd;
        string tg;
        off = base & 3;
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        tg = tag_of(sz, off);
        // Expected split, written out per case.
        if (sz == 0 || (sz == 1 && !off[0]) || (sz == 2 && off == 0)) begin
            n = 1; e_rel[0] = 0; e_sz[0] = sz;
        end else if (sz == 1) begin
            n = 2; e_rel[0] = 0; e_sz[0] = 0; e_rel[1] = 1; e_sz[1] = 0;
        end else if (off == 2) begin
            n = 2; e_rel[0] = 0; e_sz[0] = 1; e_rel[1] = 2; e_sz[1] = 1;
        end else begin
            n = 3; e_rel[0] = 0; e_sz[0] = 0; e_rel[1] = 1; e_sz[1] = 1; e_rel[2] = 3; e_sz[2] = 0;
        end
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'(i * 37 + base + w);
            ref_mem[i] = mem[i];
        end
        exp_rd = '0;
        for (int i = 0; i < nb; i++) begin
            exp_rd[8*i +: 8] = mem[6'(base + i)];
            if (wr) ref_mem[6'(base + i)] = wd[8*i +: 8];
        end
        wait_cfg = w;
        lg_n = 0;
        lane_err = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = 32'h4000_0000 + 32'(base);
        req_size = 2'(sz);
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        tmo = 0;
        while (!done && tmo < 100) begin
            if (bus_req) cyc++;
            if (hammer) begin
                req_valid = busy;
                req_addr = 32'h4000_0020;
                req_size = 2'd2;
            end
            @(negedge clk);
            tmo++;
        end
        req_valid = 1'b0;
        chk(done, "R8", "done seen", 32'(done), 32'd1);
        chk(lg_n == n, tg, "piece count", 32'(lg_n), 32'(n));
        for (int i = 0; i < 3; i++) begin
            if (i < n && i < lg_n) begin
                chk(lg_addr[i] == 32'h4000_0000 + 32'(base + e_rel[i]), tg, "piece addr",
                    lg_addr[i], 32'h4000_0000 + 32'(base + e_rel[i]));
                chk(lg_size[i] == 2'(e_sz[i]), tg, "piece size", 32'(lg_size[i]), 32'(e_sz[i]));
            end
        end
        chk(cyc == n * (w + 1), (w == 0) ? "R5" : "R10", "bus_req cycles", 32'(cyc), 32'(n * (w + 1)));
        if (wr) begin
            for (int i = 0; i < 64; i++)
                chk(mem[i] == ref_mem[i], "R6", "memory byte", 32'(mem[i]), 32'(ref_mem[i]));
            chk(lane_err == 0, "R6", "unused lanes zero", 32'(lane_err), 32'd0);
        end else begin
            chk(rdata == exp_rd, "R7", "read merge", rdata, exp_rd);
        end
        @(negedge clk);
        chk(!done, "R8", "done single pulse", 32'(done), 32'd0);
        if (hammer) begin
            for (int i = 0; i < 3; i++) begin
                chk(!bus_req && !busy, "R9", "no transfer from ignored request", 32'(bus_req), 32'd0);
                @(negedge clk);
            end
            chk(lg_n == n, "R9", "piece count after ignored request", 32'(lg_n), 32'(n));
        end
    endtask

    initial begin
        int cyc_wd;
        cyc_wd = 0;
        forever begin
            @(posedge clk);
            cyc_wd++;
            if (cyc_wd > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc_wd);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !done && !busy, "R8", "reset idle", {29'd0, bus_req, done, busy}, 32'd0);
        k = 0;
        for (int w = 0; w < 3; w++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int off = 0; off < 4; off++) begin
                        run_one(((k * 4) & 31) + 8 + off, sz, wr[0],
                                32'hA1B2_C3D4 ^ 32'(k * 32'h0101_0101),
                                (w == 2) ? 3 : w, 1'b0);
                        k++;
                    end
                end
            end
        end
        run_one(13, 2, 1'b0, 32'h0, 2, 1'b1);
        run_one(21, 2, 1'b1, 32'h5566_7788, 1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule